// File: doc/BRIEF.md
# Word-Queued I2C Bus Master

This block is an I2C bus master that takes its whole bus sequence from a queue of tagged command words. Software pushes 10-bit words into a transmit queue. Each word carries a data byte, a "begin" tag and an "end" tag. A begin-tagged word produces a start condition, or a repeated start when the master already holds the bus, and its byte is then sent as an address. Untagged words in a write phase are shifted out unchanged. In a read phase each word is only a placeholder: it makes the master clock in one byte from the slave, and that byte goes into a receive queue. An end-tagged word closes the transfer with a stop condition once its byte is finished.

A small register port gives access to control, status, the two queues, the transmit queue level and two separate SCL timing counts. The bus pins are open-drain. The outputs are pull-low enables, and the SDA input is sampled for acknowledge, read data and arbitration. An interrupt line combines the enabled status conditions. After a refused acknowledge or a lost arbitration the master stops taking words. The unsent words stay in the transmit queue until software issues a soft reset.

Top module: `i2cm_top`

## Requirements
- R1: A transmit word is formatted as bit 9 = begin tag, bit 8 = end tag and bits 7:0 = byte. A begin-tagged word makes a start condition (SDA falls while SCL is high), or a repeated start if the bus is already held. Its byte then goes out MSB first, with a slave acknowledge clock as the ninth clock. For a 7-bit address the header byte is {address, read bit}. For a 10-bit address the host sends 0xF0 | (addr[9:8] << 1), then addr[7:0], and for a read it adds a third begin-tagged header equal to the first byte with bit 0 set.
- R2: After a begin-tagged byte whose bit 0 is 1, every following untagged word clocks one byte from the slave into the receive queue, and the word's byte value has no effect. The master acknowledges each such byte (SDA low on clock 9), except a byte from an end-tagged word, which gets no acknowledge (SDA high).
- R3: An end-tagged word finishes its byte, then drives a stop condition (SDA rises while SCL is high) and sets the done flag (status bit 2).
- R4: Within a byte, each SCL low phase lasts exactly the low-count register value in clock cycles (address 6) and each high phase lasts the high-count value (address 5). Both counts must be at least 2.
- R5: If the slave does not acknowledge a written byte, the master drives a stop, sets the no-acknowledge flag (status bit 1) and the done flag, and takes no further words. The transmit level register (address 4) then reports the number of unsent words.
- R6: If SDA reads low at the end of a written data bit that the master left high, the lost-arbitration flag (status bit 0) is set, both pull-low enables drop, and no further words are taken.
- R7: Any accepted push into the transmit queue (address 2) clears the no-acknowledge flag.
- R8: Writing a 1 to status bit 2 clears the done flag.
- R9: Writing 1 to control bit 5 starts a soft reset. Bit 5 reads 1 for RST_CYC cycles and then clears by itself. The soft reset empties both queues, clears all status flags and returns the master to idle.
- R10: Status bit 3 is 1 when the transmit queue holds DEPTH words, and further pushes are then dropped. Status bit 4 is 1 when the receive queue is empty. A read of address 3 returns the oldest received byte and removes it.
- R11: The interrupt output is the OR of five conditions, each gated by a control bit: bit 0 gates lost arbitration, bit 1 gates no-acknowledge, bit 2 gates done, bit 3 gates transmit queue not full, and bit 4 gates receive data available.
- R12: After reset, both pull-low enables are 0, the interrupt is 0, the status reads 0x10 and the transmit level reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register select: 0 ctrl, 1 status, 2 TX push, 3 RX pop, 4 TX level, 5 SCL high count, 6 SCL low count |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX at address 3) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| irq | output | 1 | Interrupt request |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest state to reach is lost arbitration, because a second master has to pull SDA low in exactly the high phase of a bit that this master leaves released. The bench tracks the SCL enable and forces the shared line low during the first high phase of an address byte whose MSB is 1. It then uses the halted master to fill the transmit queue to its limit. The other hard case is a 10-bit write-then-read with a repeated start. A behavioural slave on the wired-AND bus logs every byte, every start and stop, and the master's acknowledge bits.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam int REG_W = 16;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_TX   = 3'd2;
    localparam logic [2:0] A_RX   = 3'd3;
    localparam logic [2:0] A_TXL  = 3'd4;
    localparam logic [2:0] A_HI   = 3'd5;
    localparam logic [2:0] A_LO   = 3'd6;

    typedef struct packed {
        logic       beg;
        logic       fin;
        logic [7:0] data;
    } txw_t;

    typedef enum logic [3:0] {
        E_IDLE, E_RSLO, E_SHI, E_SLOW, E_BLO, E_BHI,
        E_PLO, E_PHI, E_PREL, E_WAIT, E_HALT
    } est_t;

    function automatic logic scl_pulled(est_t s);
        return (s == E_RSLO) || (s == E_BLO) || (s == E_PLO) || (s == E_WAIT);
    endfunction
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, empty, do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] adv(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0; rp <= '0; level <= '0;
        end else begin
            if (do_push) wp <= adv(wp);
            if (do_pop)  rp <= adv(rp);
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

    // R10
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (level == $past(level)));
    // R10
    level_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> (level == $past(level) + 1'b1));
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] hi_cnt,
    input  logic [CW-1:0] lo_cnt,
    input  logic          word_valid,
    input  txw_t          word,
    output logic          word_take,
    input  logic          sda_in,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          rx_push,
    output logic [7:0]    rx_byte,
    output logic          ev_afi,
    output logic          ev_nai,
    output logic          ev_tdi
);
    est_t          st, st_n;
    logic [CW-1:0] tmr, per;
    logic          tdone, cur_beg, cur_fin, rd_mode, cur_rd, nak_halt, sda_drv, drv_bit;
    logic [3:0]    bitn;
    logic [7:0]    sh;

    assign scl_oe  = scl_pulled(st);
    assign sda_oe  = sda_drv;
    assign rx_byte = sh;
    assign per     = scl_pulled(st) ? lo_cnt : hi_cnt;
    assign tdone   = (tmr + 1'b1) >= per;
    assign cur_rd  = rd_mode && !cur_beg;
    assign drv_bit = (bitn < 4'd8) ? (cur_rd ? 1'b0 : ~sh[7])
                                   : (cur_rd ? ~cur_fin : 1'b0);

    always_comb begin
        st_n = st; word_take = 1'b0; rx_push = 1'b0;
        ev_afi = 1'b0; ev_nai = 1'b0; ev_tdi = 1'b0;
        case (st)
            E_IDLE: if (word_valid) begin
                word_take = 1'b1;
                if (word.beg) st_n = E_SHI;
            end
            E_WAIT: if (word_valid) begin
                word_take = 1'b1;
                st_n = word.beg ? E_RSLO : E_BLO;
            end
            E_RSLO: if (tdone) st_n = E_SHI;
            E_SHI:  if (tdone) st_n = E_SLOW;
            E_SLOW: if (tdone) st_n = E_BLO;
            E_BLO:  if (tdone) st_n = E_BHI;
            E_BHI:  if (tdone) begin
                if (bitn < 4'd8) begin
                    if (!cur_rd && sh[7] && !sda_in) begin
                        ev_afi = 1'b1; st_n = E_HALT;
                    end else begin
                        st_n = E_BLO;
                    end
                end else if (!cur_rd && sda_in) begin
                    ev_nai = 1'b1; st_n = E_PLO;
                end else begin
                    rx_push = cur_rd;
                    st_n = cur_fin ? E_PLO : E_WAIT;
                end
            end
            E_PLO:  if (tdone) st_n = E_PHI;
            E_PHI:  if (tdone) st_n = E_PREL;
            E_PREL: if (tdone) begin
                ev_tdi = 1'b1;
                st_n = nak_halt ? E_HALT : E_IDLE;
            end
            default: st_n = st;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= E_IDLE; tmr <= '0; bitn <= '0; sh <= '0; sda_drv <= 1'b0;
            cur_beg <= 1'b0; cur_fin <= 1'b0; rd_mode <= 1'b0; nak_halt <= 1'b0;
        end else begin
            st       <= st_n;
            tmr      <= (st_n != st) ? '0 : tmr + 1'b1;
            nak_halt <= nak_halt | ev_nai;
            if (word_take) begin
                cur_beg <= word.beg;
                cur_fin <= word.fin;
                sh      <= word.data;
                bitn    <= '0;
                if (word.beg) rd_mode <= word.data[0];
            end else if (st == E_BHI && tdone && bitn < 4'd8) begin
                sh   <= {sh[6:0], sda_in};
                bitn <= bitn + 1'b1;
            end
            if (st_n == E_HALT || (st == E_PHI && st_n == E_PREL) ||
                st == E_RSLO || st == E_WAIT)
                sda_drv <= 1'b0;
            else if (st == E_SHI && st_n == E_SLOW)
                sda_drv <= 1'b1;
            else if (st == E_BLO)
                sda_drv <= drv_bit;
            else if (st == E_PLO)
                sda_drv <= 1'b1;
        end
    end

    // R6
    afi_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev_afi |=> (!scl_oe && !sda_oe));
    // R3
    stop_lines_chk: assert property (@(posedge clk) disable iff (rst)
        ev_tdi |-> (!scl_oe && !sda_oe));
endmodule

// File: rtl/i2cm_top.sv
module i2cm_top
    import i2cm_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int CW      = 16,
    parameter int CNT_DEF = 8,
    parameter int RST_CYC = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    input  logic        sda_in,
    output logic        scl_oe,
    output logic        sda_oe
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int RW = $clog2(RST_CYC + 1);

    logic [4:0]    ie;
    logic [CW-1:0] hi, lo;
    logic          afi, nai, tdi, rst_busy, srst;
    logic [RW-1:0] rst_cnt;
    logic [LW-1:0] tx_lvl, rx_lvl;
    logic          tx_full, rx_empty, tx_push, rx_pop, take, rx_push;
    logic          ev_afi, ev_nai, ev_tdi;
    logic [9:0]    tx_dout;
    logic [7:0]    rx_byte, rx_dout;
    txw_t          head;

    assign srst     = rst | rst_busy;
    assign tx_full  = (tx_lvl == LW'(DEPTH));
    assign rx_empty = (rx_lvl == '0);
    assign tx_push  = reg_wr && reg_addr == A_TX && !tx_full;
    assign rx_pop   = reg_rd && reg_addr == A_RX;
    assign head     = txw_t'(tx_dout);
    assign irq      = |(ie & {!rx_empty, !tx_full, tdi, nai, afi});

    i2cm_fifo #(.W(10), .DEPTH(DEPTH)) i_txq (
        .clk(clk), .rst(srst), .push(tx_push), .din(reg_wdata[9:0]),
        .pop(take), .dout(tx_dout), .level(tx_lvl));

    i2cm_fifo #(.W(8), .DEPTH(DEPTH)) i_rxq (
        .clk(clk), .rst(srst), .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .dout(rx_dout), .level(rx_lvl));

    i2cm_engine #(.CW(CW)) i_eng (
        .clk(clk), .rst(srst), .hi_cnt(hi), .lo_cnt(lo),
        .word_valid(tx_lvl != '0), .word(head), .word_take(take),
        .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .rx_push(rx_push), .rx_byte(rx_byte),
        .ev_afi(ev_afi), .ev_nai(ev_nai), .ev_tdi(ev_tdi));

    always_ff @(posedge clk) begin
        if (rst) begin
            ie <= '0; hi <= CW'(CNT_DEF); lo <= CW'(CNT_DEF);
            rst_busy <= 1'b0; rst_cnt <= '0;
        end else begin
            if (reg_wr && reg_addr == A_CTRL) ie <= reg_wdata[4:0];
            if (reg_wr && reg_addr == A_HI)   hi <= reg_wdata[CW-1:0];
            if (reg_wr && reg_addr == A_LO)   lo <= reg_wdata[CW-1:0];
            if (rst_busy) begin
                rst_cnt <= rst_cnt + 1'b1;
                if (rst_cnt == RW'(RST_CYC - 1)) rst_busy <= 1'b0;
            end else if (reg_wr && reg_addr == A_CTRL && reg_wdata[5]) begin
                rst_busy <= 1'b1;
                rst_cnt  <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            afi <= 1'b0; nai <= 1'b0; tdi <= 1'b0;
        end else begin
            if (ev_afi) afi <= 1'b1;
            if (ev_nai)       nai <= 1'b1;
            else if (tx_push) nai <= 1'b0;
            if (ev_tdi) tdi <= 1'b1;
            else if (reg_wr && reg_addr == A_STAT && reg_wdata[2]) tdi <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {10'b0, rst_busy, ie};
            A_STAT:  reg_rdata = {11'b0, rx_empty, tx_full, tdi, nai, afi};
            A_RX:    reg_rdata = {8'b0, rx_dout};
            A_TXL:   reg_rdata = REG_W'(tx_lvl);
            A_HI:    reg_rdata = REG_W'(hi);
            A_LO:    reg_rdata = REG_W'(lo);
            default: reg_rdata = '0;
        endcase
    end

    // R7
    nai_clear_chk: assert property (@(posedge clk) disable iff (srst)
        (tx_push && !ev_nai) |=> !nai);
    // R9
    soft_rst_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_busy) |-> (!afi && !nai && !tdi && tx_lvl == '0 && rx_empty));
    // R5
    nai_with_stop_chk: assert property (@(posedge clk) disable iff (srst)
        ev_nai |=> scl_oe);
endmodule

// File: tb/test_i2cm_top.sv
module test_i2cm_top;
    localparam int DEPTH = 8;
    localparam logic [6:0] SADDR = 7'h52;

    logic        clk = 1'b0, rst = 1'b1;
    logic [2:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] wdata = '0, rdata;
    logic        irq, scl_oe, sda_oe;
    logic        slv_drv = 1'b0, arb_force = 1'b0;
    wire         scl_w = ~scl_oe;
    wire         sda_w = ~(sda_oe | slv_drv | arb_force);

    int n_chk = 0, n_fail = 0;

    i2cm_top #(.DEPTH(DEPTH)) i_i2cm_top (
        .clk(clk), .rst(rst), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq), .sda_in(sda_w),
        .scl_oe(scl_oe), .sda_oe(sda_oe));

    always #2 clk = ~clk;

    // behavioural slave
    int start_cnt = 0, stop_cnt = 0, bn = 0, mn = 0, bitn = 0, ridx = 0;
    logic [7:0] blog [64];
    logic       mack [64];
    logic [7:0] shr = '0, rbyte;
    logic in_x = 1'b0, first = 1'b0, pend_rd = 1'b0, rdph = 1'b0, ackp = 1'b0, rd_done = 1'b0;

    function automatic logic [7:0] slv_data(int i);
        return 8'h3C ^ 8'(i * 29);
    endfunction

    always @(negedge sda_w) if (scl_w === 1'b1) begin
        start_cnt++; in_x = 1; first = 1; bitn = 0; rdph = 0; ackp = 0;
        rd_done = 0; ridx = 0; slv_drv = 0;
    end
    always @(posedge sda_w) if (scl_w === 1'b1) begin
        stop_cnt++; in_x = 0; slv_drv = 0;
    end
    always @(posedge scl_w) if (in_x) begin
        if (bitn < 8) begin
            if (!rdph) shr = {shr[6:0], sda_w};
            bitn++;
            if (bitn == 8 && !rdph) begin
                if (bn < 64) blog[bn] = shr;
                bn++;
                if (first) begin
                    ackp = (shr[7:1] == SADDR) || (shr[7:3] == 5'b11110);
                    pend_rd = shr[0];
                end else ackp = 1;
            end
        end else begin
            bitn = 0;
            if (rdph) begin
                if (mn < 64) mack[mn] = sda_w;
                mn++; ridx++;
                if (sda_w) rd_done = 1;
            end else begin
                if (first && ackp && pend_rd) rdph = 1;
                first = 0;
                if (!ackp) in_x = 0;
            end
        end
    end
    always @(negedge scl_w) begin
        if (in_x && bitn == 8 && !rdph) slv_drv = ackp;
        else if (in_x && rdph && bitn < 8 && !rd_done) begin
            rbyte = slv_data(ridx);
            slv_drv = ~rbyte[7 - bitn];
        end else slv_drv = 0;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic push(input logic b, input logic f, input logic [7:0] v);
        reg_wr(3'd2, {6'b0, b, f, v});
    endtask

    task automatic wait_done();
        logic [15:0] s;
        for (int i = 0; i < 4000; i++) begin
            reg_rd(3'd1, s);
            if (s[2] || s[0]) break;
        end
    endtask

    task automatic clr_logs();
        start_cnt = 0; stop_cnt = 0; bn = 0; mn = 0;
    endtask

    task automatic soft_reset();
        logic [15:0] v;
        reg_wr(3'd0, 16'h0020);
        repeat (8) @(negedge clk);
        reg_rd(3'd0, v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  exp_b [8];
        int n, lowlen, hilen;
        logic [9:0] a10;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        chk("R12 oe", {scl_oe, sda_oe, irq}, 0);
        reg_rd(3'd1, v); chk("R12 status", v, 16'h0010);
        reg_rd(3'd4, v); chk("R12 txlevel", v, 0);

        reg_wr(3'd5, 16'd3);
        reg_wr(3'd6, 16'd4);

        // R1 R3: random 7-bit writes
        for (int it = 0; it < 4; it++) begin
            clr_logs();
            n = 1 + int'($urandom % 4);
            push(1'b1, 1'b0, {SADDR, 1'b0});
            for (int k = 0; k < n; k++) begin
                exp_b[k] = 8'($urandom);
                push(1'b0, k == n - 1, exp_b[k]);
            end
            wait_done();
            chk("R1 byte count", bn, n + 1);
            chk("R1 header", blog[0], {SADDR, 1'b0});
            for (int k = 0; k < n; k++) chk("R1 data", blog[k + 1], exp_b[k]);
            chk("R3 starts", start_cnt, 1);
            chk("R3 stops", stop_cnt, 1);
            reg_rd(3'd1, v); chk("R3 done flag", v[2:0], 3'b100);
            reg_wr(3'd1, 16'h0004);
            reg_rd(3'd1, v); chk("R8 done cleared", v[2], 0);
        end

        // R2: random reads, dummy values are random
        for (int it = 0; it < 3; it++) begin
            clr_logs();
            n = 1 + int'($urandom % 4);
            push(1'b1, 1'b0, {SADDR, 1'b1});
            for (int k = 0; k < n; k++) push(1'b0, k == n - 1, 8'($urandom));
            wait_done();
            for (int k = 0; k < n; k++) begin
                reg_rd(3'd3, v); chk("R2 rx data", v[7:0], slv_data(k));
                chk("R2 master ack", mack[k], (k == n - 1) ? 1 : 0);
            end
            reg_rd(3'd1, v); chk("R10 rx empty", v[4], 1);
            reg_wr(3'd1, 16'h0004);
        end

        // R1: 10-bit address write then read with repeated start
        clr_logs();
        a10 = 10'h2D5;
        push(1'b1, 1'b0, 8'hF0 | {5'b0, a10[9:8], 1'b0});
        push(1'b0, 1'b0, a10[7:0]);
        push(1'b1, 1'b0, 8'hF0 | {5'b0, a10[9:8], 1'b1});
        push(1'b0, 1'b0, 8'h00);
        push(1'b0, 1'b1, 8'hFF);
        wait_done();
        chk("R1 10b first", blog[0], 8'hF4);
        chk("R1 10b low", blog[1], 8'hD5);
        chk("R1 10b third", blog[2], 8'hF5);
        chk("R1 repeated start", start_cnt, 2);
        reg_rd(3'd3, v); chk("R2 10b rx0", v[7:0], slv_data(0));
        reg_rd(3'd3, v); chk("R2 10b rx1", v[7:0], slv_data(1));
        reg_wr(3'd1, 16'h0004);

        // R4: asymmetric SCL timing
        reg_wr(3'd5, 16'd5);
        reg_wr(3'd6, 16'd8);
        push(1'b1, 1'b0, {SADDR, 1'b0});
        push(1'b0, 1'b1, 8'hA5);
        while (!scl_oe) @(negedge clk);
        lowlen = 0; while (scl_oe) begin lowlen++; @(negedge clk); end
        hilen = 0;  while (!scl_oe) begin hilen++; @(negedge clk); end
        chk("R4 low time", lowlen, 8);
        chk("R4 high time", hilen, 5);
        wait_done();
        reg_wr(3'd1, 16'h0004);
        reg_wr(3'd5, 16'd3);
        reg_wr(3'd6, 16'd4);

        // R11: done interrupt, then rx-available interrupt
        reg_wr(3'd0, 16'h0004);
        push(1'b1, 1'b0, {SADDR, 1'b0});
        push(1'b0, 1'b1, 8'h11);
        wait_done();
        @(negedge clk); chk("R11 irq done", irq, 1);
        reg_wr(3'd1, 16'h0004);
        @(negedge clk); chk("R11 irq cleared", irq, 0);
        reg_wr(3'd0, 16'h0010);
        push(1'b1, 1'b0, {SADDR, 1'b1});
        push(1'b0, 1'b1, 8'h00);
        wait_done();
        @(negedge clk); chk("R11 irq rx", irq, 1);
        reg_rd(3'd3, v);
        @(negedge clk); chk("R11 irq rx popped", irq, 0);
        reg_wr(3'd0, 16'h0000);
        reg_wr(3'd1, 16'h0004);

        // R5 R7: refused address
        clr_logs();
        push(1'b1, 1'b0, {7'h11, 1'b0});
        push(1'b0, 1'b0, 8'h01);
        push(1'b0, 1'b0, 8'h02);
        push(1'b0, 1'b1, 8'h03);
        wait_done();
        repeat (4) @(negedge clk);
        reg_rd(3'd1, v); chk("R5 nak+done", v[2:0], 3'b110);
        reg_rd(3'd4, v); chk("R5 unsent level", v, 3);
        chk("R5 stop", stop_cnt, 1);
        chk("R5 lines", {scl_oe, sda_oe}, 0);
        push(1'b0, 1'b0, 8'h04);
        reg_rd(3'd1, v); chk("R7 nak cleared", v[1], 0);
        reg_rd(3'd4, v); chk("R5 halted level", v, 4);

        // R9: soft reset
        reg_wr(3'd0, 16'h0020);
        reg_rd(3'd0, v); chk("R9 busy", v[5], 1);
        repeat (6) @(negedge clk);
        reg_rd(3'd0, v); chk("R9 self clear", v[5], 0);
        reg_rd(3'd4, v); chk("R9 tx flushed", v, 0);
        reg_rd(3'd1, v); chk("R9 status", v, 16'h0010);

        // R6: lost arbitration on first address bit
        push(1'b1, 1'b0, 8'hC0);
        push(1'b0, 1'b0, 8'h01);
        push(1'b0, 1'b1, 8'h02);
        while (!scl_oe) @(negedge clk);
        while (scl_oe) @(negedge clk);
        arb_force = 1'b1;
        repeat (10) @(negedge clk);
        arb_force = 1'b0;
        reg_rd(3'd1, v); chk("R6 afi", v[0], 1);
        chk("R6 lines released", {scl_oe, sda_oe}, 0);
        repeat (40) begin
            @(negedge clk);
            if (scl_oe) chk("R6 bus quiet", 1, 0);
        end
        reg_rd(3'd4, v); chk("R6 words kept", v, 2);

        // R10: fill while halted
        for (int k = 0; k < DEPTH + 2; k++) push(1'b0, 1'b0, 8'(k));
        reg_rd(3'd4, v); chk("R10 level cap", v, DEPTH);
        reg_rd(3'd1, v); chk("R10 full flag", v[3], 1);
        soft_reset();
        reg_rd(3'd1, v); chk("R10 full cleared", v[3], 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule